// File: doc/BRIEF.md
# Decimated IQ Lane Framer

This block places decimated in-phase and quadrature samples from one or two demodulator channels onto a single serial output lane. The lane keeps emitting one frame per undecimated sample period even though fresh samples only arrive once every M sample periods. Frames that carry no sample are filled with zero words. After reset the lane sends a sync word first. It then sends zero frames until the first decimated valid strobe. From then on it repeats a group of M frames: the data words in a fixed order, followed by zero padding.

The lane advances one bit per clock cycle in which `bit_en` is high. A frame is 16 bits long, or 14 bits when the narrow frame setting is selected. Words go out MSB first. A frame-marker output is high for the first half of every frame. Samples arrive on four 16-bit inputs together with a one-cycle strobe. They are held until the next group starts, so a strobe in the middle of a group never corrupts the group that is already being sent.

Top module: `iq_lane_framer`

## Requirements
- R1: After reset the first frame carries the sync word `SYNC_WORD` (its top W bits, MSB first). Every later frame is all zeros until the first `smp_vld` strobe.
- R2: The group counter starts at slot 0 in the frame that follows the frame in which the first `smp_vld` strobe occurred. It then wraps every `dec_factor` frames.
- R3: With `dual_ch`=0 and `one_comp`=0, each group sends ch0 I, then ch0 Q, then `dec_factor`-2 zero words.
- R4: With `dual_ch`=1 and `one_comp`=0, each group sends ch0 I, ch0 Q, ch1 I, ch1 Q, then `dec_factor`-4 zero words.
- R5: With `one_comp`=1, each group sends only one component per channel: I when `pick_q`=0, Q when `pick_q`=1. The order is ch0 then ch1 (when `dual_ch`=1), and `dec_factor`-1 or `dec_factor`-2 zero words follow.
- R6: The frame width W is 16 bits when `narrow_frame`=0 and 14 bits when it is 1. The frame holds the top W bits of the 16-bit word. `frm_mark` is 1 for the first W/2 bits of every frame and 0 for the rest.
- R7: With `full_res`=0, bits [1:0] of every sample word are sent as zero. With `full_res`=1, all 16 bits are sent.
- R8: When `dec_factor` is smaller than the number of data words per group (2, 4, 1 or 2 for the modes of R3, R4 and R5), `cfg_err` is 1 and `ser_out` is 0 for every bit, sync included.
- R9: While `bit_en` is 0, `ser_out` and `frm_mark` hold their values and the lane does not advance.
- R10: A strobe in the middle of a group updates only the held sample. The group in progress keeps its words, and the latest held sample is used at the next slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Advance the lane by one bit |
| dec_factor | input | MW | Decimation factor M |
| dual_ch | input | 1 | Two channels share the lane |
| one_comp | input | 1 | Send one component per channel instead of I and Q |
| pick_q | input | 1 | Component chosen in one-component mode (0 = I, 1 = Q) |
| narrow_frame | input | 1 | 14-bit frames instead of 16-bit |
| full_res | input | 1 | Keep all 16 sample bits |
| smp_vld | input | 1 | Decimated sample strobe |
| ch0_i | input | 16 | Channel 0 in-phase sample |
| ch0_q | input | 16 | Channel 0 quadrature sample |
| ch1_i | input | 16 | Channel 1 in-phase sample |
| ch1_q | input | 16 | Channel 1 quadrature sample |
| ser_out | output | 1 | Serial lane bit |
| frm_mark | output | 1 | Frame marker |
| cfg_err | output | 1 | Decimation factor too small for the mode |

## Verification
The bench targets the boundaries where the padding count reaches zero. These are M=2 with one channel and M=4 with two channels, where a design that counted the pad wrongly would slip a zero word into the group or repeat a word. It also targets the first strobe after sync: a counter started off by one frame would shift every group by a slot. Strobes in every frame test whether data is latched at the group boundary; a design that latched on every strobe would mix words from different samples inside a group. The remaining targets are 14-bit frames, where a marker or word placed by 16-bit arithmetic would show up misaligned; gaps in `bit_en`; and a too-small M, where a design that did not gate its output would still send sync and data.

// File: rtl/lf_pkg.sv
package lf_pkg;
  localparam int LF_WORD_W   = 16;
  localparam int LF_NARROW_W = 14;
  localparam int LF_POS_W    = $clog2(LF_WORD_W);
  localparam int LF_LOW_CUT  = LF_WORD_W - LF_NARROW_W;

  typedef enum logic [1:0] {ST_SYNC, ST_WAIT, ST_RUN} lane_st_e;

  typedef struct packed {
    logic [LF_WORD_W-1:0] i0;
    logic [LF_WORD_W-1:0] q0;
    logic [LF_WORD_W-1:0] i1;
    logic [LF_WORD_W-1:0] q1;
  } lf_grp_t;

  // data words that one group carries for a mode
  function automatic logic [2:0] words_per_grp(input logic dual, input logic one);
    if (one) return dual ? 3'd2 : 3'd1;
    return dual ? 3'd4 : 3'd2;
  endfunction

  // word carried in a given slot, zero when the slot is padding
  function automatic logic [LF_WORD_W-1:0] slot_word(input int slot, input lf_grp_t g,
                                                     input logic dual, input logic one,
                                                     input logic pq);
    logic [LF_WORD_W-1:0] w;
    w = '0;
    if (one) begin
      if (slot == 0) w = pq ? g.q0 : g.i0;
      else if (slot == 1 && dual) w = pq ? g.q1 : g.i1;
    end else begin
      case (slot)
        0: w = g.i0;
        1: w = g.q0;
        2: if (dual) w = g.i1;
        3: if (dual) w = g.q1;
        default: w = '0;
      endcase
    end
    return w;
  endfunction

  // drop the low bits when the narrow resolution is in use
  function automatic logic [LF_WORD_W-1:0] trim_res(input logic [LF_WORD_W-1:0] w,
                                                    input logic full);
    if (full) return w;
    return {w[LF_WORD_W-1:LF_LOW_CUT], {LF_LOW_CUT{1'b0}}};
  endfunction
endpackage

// File: rtl/lf_bit_ctr.sv
module lf_bit_ctr
  import lf_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_en,
  input  logic                narrow,
  output logic [LF_POS_W-1:0] bpos,
  output logic                frm_end,
  output logic                frm_mark
);
  logic [LF_POS_W-1:0] last_pos;
  logic [LF_POS_W-1:0] half_pos;

  assign last_pos = narrow ? LF_POS_W'(LF_NARROW_W - 1) : LF_POS_W'(LF_WORD_W - 1);
  assign half_pos = narrow ? LF_POS_W'(LF_NARROW_W / 2) : LF_POS_W'(LF_WORD_W / 2);
  assign frm_end  = bit_en && (bpos == last_pos);
  assign frm_mark = bpos < half_pos;

  always_ff @(posedge clk) begin
    if (!rst_n)       bpos <= '0;
    else if (frm_end) bpos <= '0;
    else if (bit_en)  bpos <= bpos + 1'b1;
  end

  a_r6_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
    bpos <= last_pos);
  a_r6_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    frm_end |=> (bpos == '0));
endmodule

// File: rtl/lf_slot_seq.sv
module lf_slot_seq
  import lf_pkg::*;
#(
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frm_end,
  input  logic          smp_vld,
  input  logic [MW-1:0] dec_factor,
  input  lf_grp_t       grp_in,
  output logic          running,
  output logic          nxt_run,
  output logic [MW-1:0] nxt_slot,
  output lf_grp_t       nxt_grp
);
  lane_st_e      st, st_n;
  logic [MW-1:0] slot, slot_n;
  logic [MW:0]   slot_inc;
  logic          grp_wrap;
  logic          pend, pend_n;
  lf_grp_t       hold, hold_n, cur, cur_n;

  assign slot_inc = {1'b0, slot} + (MW+1)'(1);
  assign grp_wrap = slot_inc >= {1'b0, dec_factor};

  always_comb begin
    hold_n = smp_vld ? grp_in : hold;
    pend_n = pend | smp_vld;
    st_n   = st;
    slot_n = slot;
    cur_n  = cur;
    if (frm_end) begin
      if (st == ST_RUN) begin
        if (grp_wrap) begin
          slot_n = '0;
          cur_n  = hold_n;
        end else begin
          slot_n = slot_inc[MW-1:0];
        end
      end else if (pend_n) begin
        st_n   = ST_RUN;
        slot_n = '0;
        cur_n  = hold_n;
      end else begin
        st_n = ST_WAIT;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_SYNC;
      slot <= '0;
      pend <= 1'b0;
      hold <= '0;
      cur  <= '0;
    end else begin
      st   <= st_n;
      slot <= slot_n;
      pend <= pend_n;
      hold <= hold_n;
      cur  <= cur_n;
    end
  end

  assign running  = (st == ST_RUN);
  assign nxt_run  = (st_n == ST_RUN);
  assign nxt_slot = slot_n;
  assign nxt_grp  = cur_n;

  a_r2_start_slot0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> (slot == '0));
  a_r2_stay_run: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> running);
  a_r3_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (running && dec_factor != '0) |-> (slot < dec_factor));
  a_r10_cur_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !(frm_end && grp_wrap)) |=> $stable(cur));
endmodule

// File: rtl/lf_word_pick.sv
module lf_word_pick
  import lf_pkg::*;
#(
  parameter int MW = 8
) (
  input  logic                 active,
  input  logic [MW-1:0]        slot,
  input  lf_grp_t              grp,
  input  logic                 dual,
  input  logic                 one,
  input  logic                 pq,
  input  logic                 full,
  output logic [LF_WORD_W-1:0] word
);
  logic [LF_WORD_W-1:0] raw;

  assign raw  = slot_word(int'(slot), grp, dual, one, pq);
  assign word = active ? trim_res(raw, full) : '0;
endmodule

// File: rtl/iq_lane_framer.sv
module iq_lane_framer
  import lf_pkg::*;
#(
  parameter int                   MW        = 8,
  parameter logic [LF_WORD_W-1:0] SYNC_WORD = 16'hB38F
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_en,
  input  logic [MW-1:0]        dec_factor,
  input  logic                 dual_ch,
  input  logic                 one_comp,
  input  logic                 pick_q,
  input  logic                 narrow_frame,
  input  logic                 full_res,
  input  logic                 smp_vld,
  input  logic [LF_WORD_W-1:0] ch0_i,
  input  logic [LF_WORD_W-1:0] ch0_q,
  input  logic [LF_WORD_W-1:0] ch1_i,
  input  logic [LF_WORD_W-1:0] ch1_q,
  output logic                 ser_out,
  output logic                 frm_mark,
  output logic                 cfg_err
);
  logic [LF_POS_W-1:0]  bpos;
  logic                 frm_end;
  logic                 running;
  logic                 nxt_run;
  logic [MW-1:0]        nxt_slot;
  lf_grp_t              nxt_grp;
  lf_grp_t              grp_in;
  logic [2:0]           wpg;
  logic [LF_WORD_W-1:0] next_word;
  logic [LF_WORD_W-1:0] shreg;

  assign grp_in  = '{i0: ch0_i, q0: ch0_q, i1: ch1_i, q1: ch1_q};
  assign wpg     = words_per_grp(dual_ch, one_comp);
  assign cfg_err = {{(MW-3){1'b0}}, wpg} > dec_factor;

  lf_bit_ctr u_bit_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .narrow   (narrow_frame),
    .bpos     (bpos),
    .frm_end  (frm_end),
    .frm_mark (frm_mark)
  );

  lf_slot_seq #(.MW(MW)) u_slot_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .frm_end    (frm_end),
    .smp_vld    (smp_vld),
    .dec_factor (dec_factor),
    .grp_in     (grp_in),
    .running    (running),
    .nxt_run    (nxt_run),
    .nxt_slot   (nxt_slot),
    .nxt_grp    (nxt_grp)
  );

  lf_word_pick #(.MW(MW)) u_word_pick (
    .active (nxt_run && !cfg_err),
    .slot   (nxt_slot),
    .grp    (nxt_grp),
    .dual   (dual_ch),
    .one    (one_comp),
    .pq     (pick_q),
    .full   (full_res),
    .word   (next_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       shreg <= SYNC_WORD;
    else if (frm_end) shreg <= next_word;
    else if (bit_en)  shreg <= {shreg[LF_WORD_W-2:0], 1'b0};
  end

  assign ser_out = shreg[LF_WORD_W-1] & ~cfg_err;

  a_r8_err_load: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_end && cfg_err) |=> (shreg == '0));
  a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !ser_out);
  a_r3_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_end && nxt_run && nxt_slot >= {{(MW-3){1'b0}}, wpg}) |=> (shreg == '0));
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_end && !nxt_run) |=> (shreg == '0));
  a_r9_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && $stable(cfg_err)) |=> ($stable(ser_out) && $stable(frm_mark)));
  a_r2_run_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> $past(frm_end));
endmodule

// File: tb/test_iq_lane_framer.sv
module test_iq_lane_framer;
  localparam int          CLK_PERIOD = 10;
  localparam int          MW         = 8;
  localparam logic [15:0] SYNC       = 16'hB38F;
  localparam int          WD_CYCLES  = 150000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bit_en = 1'b0;
  logic [MW-1:0] dec_factor = 8'd3;
  logic          dual_ch = 1'b0, one_comp = 1'b0, pick_q = 1'b0;
  logic          narrow_frame = 1'b0, full_res = 1'b0, smp_vld = 1'b0;
  logic [15:0]   ch0_i = '0, ch0_q = '0, ch1_i = '0, ch1_q = '0;
  logic          ser_out, frm_mark, cfg_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  iq_lane_framer #(.MW(MW), .SYNC_WORD(SYNC)) i_iq_lane_framer (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .dec_factor(dec_factor),
    .dual_ch(dual_ch), .one_comp(one_comp), .pick_q(pick_q),
    .narrow_frame(narrow_frame), .full_res(full_res), .smp_vld(smp_vld),
    .ch0_i(ch0_i), .ch0_q(ch0_q), .ch1_i(ch1_i), .ch1_q(ch1_q),
    .ser_out(ser_out), .frm_mark(frm_mark), .cfg_err(cfg_err)
  );

  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [15:0] got, input logic [15:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, expv);
    end
  endtask

  // monitor: assembles frames from the lane and compares against the queue
  int          mbit = 0;
  logic [15:0] acc = '0;
  bit          stall_seen = 1'b0;
  logic        stall_bit, stall_fm;
  always @(negedge clk) begin
    int          w;
    logic [31:0] msk;
    logic [15:0] expv;
    string       tg;
    w = narrow_frame ? 14 : 16;
    if (!rst_n) begin
      mbit = 0;
      stall_seen = 1'b0;
    end else if (!bit_en) begin
      stall_seen = 1'b1;
      stall_bit  = ser_out;
      stall_fm   = frm_mark;
    end else begin
      if (stall_seen) begin
        chk(ser_out == stall_bit && frm_mark == stall_fm, "R9", "held bit/marker",
            {14'd0, frm_mark, ser_out}, {14'd0, stall_fm, stall_bit});
        stall_seen = 1'b0;
      end
      if (frm_mark != (mbit < w/2)) begin
        chk(1'b0, "R6", "frame marker", 16'(frm_mark), 16'(mbit < w/2));
      end
      acc  = {acc[14:0], ser_out};
      mbit = mbit + 1;
      if (mbit == w) begin
        mbit = 0;
        msk  = (32'h1 << w) - 32'h1;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1", "unexpected frame", acc & msk[15:0], 16'h0);
        end else begin
          expv = exp_q.pop_front();
          tg   = tag_q.pop_front();
          chk((acc & msk[15:0]) == (expv >> (16 - w)), tg, "frame word",
              acc & msk[15:0], expv >> (16 - w));
        end
      end
    end
  end

  // bench's own model of the group layout
  bit          started;
  int          slot;
  int          m_cfg;
  bit          err_cfg;
  logic [15:0] hold[4];
  logic [15:0] cur[4];
  string       cur_tag;

  function automatic int n_words();
    if (one_comp) return dual_ch ? 2 : 1;
    return dual_ch ? 4 : 2;
  endfunction

  function automatic logic [15:0] model_word(input int s);
    logic [15:0] lst[4];
    logic [15:0] r;
    if (one_comp) begin
      lst[0] = pick_q ? cur[1] : cur[0];
      lst[1] = pick_q ? cur[3] : cur[2];
    end else begin
      for (int k = 0; k < 4; k++) lst[k] = cur[k];
    end
    r = (s < n_words()) ? lst[s] : 16'h0;
    if (!full_res) r[1:0] = 2'b00;
    return r;
  endfunction

  task automatic push(input logic [15:0] w);
    exp_q.push_back(w);
    tag_q.push_back(cur_tag);
  endtask

  task automatic start(input int m, input bit dual, input bit one, input bit pq,
                       input bit nar, input bit full, input string tag);
    rst_n = 1'b0;
    bit_en = 1'b0;
    smp_vld = 1'b0;
    dec_factor = MW'(m);
    dual_ch = dual; one_comp = one; pick_q = pq;
    narrow_frame = nar; full_res = full;
    repeat (3) @(posedge clk);
    #1;
    exp_q.delete();
    tag_q.delete();
    cur_tag = tag;
    m_cfg = m;
    started = 1'b0;
    slot = 0;
    for (int k = 0; k < 4; k++) begin
      hold[k] = '0;
      cur[k]  = '0;
    end
    err_cfg = (m < n_words());
    push(err_cfg ? 16'h0 : SYNC);
    rst_n = 1'b1;
    #1;
    chk(cfg_err == err_cfg, err_cfg ? "R8" : "R1", "cfg_err after reset",
        16'(cfg_err), 16'(err_cfg));
    chk(frm_mark == 1'b1, "R6", "marker after reset", 16'(frm_mark), 16'h1);
    chk(ser_out == (err_cfg ? 1'b0 : SYNC[15]), "R1", "first lane bit",
        16'(ser_out), 16'(err_cfg ? 1'b0 : SYNC[15]));
  endtask

  task automatic run(input int nfr, input int first_v, input int every, input bit stall);
    int  w;
    bit  v;
    w = narrow_frame ? 14 : 16;
    for (int f = 0; f < nfr; f++) begin
      v = (f >= first_v) && (((f - first_v) % every) == 0);
      if (v) begin
        ch0_i = 16'(16'h1357 * (f + 1) + 16'h0003);
        ch0_q = 16'(16'h2A4D * (f + 3) + 16'h0001);
        ch1_i = 16'(16'h3C61 * (f + 5) + 16'h0002);
        ch1_q = 16'(16'h4E7B * (f + 7) + 16'h0003);
      end
      for (int b = 0; b < w; b++) begin
        smp_vld = v && (b == w/2);
        bit_en  = 1'b1;
        @(posedge clk);
        #1;
        smp_vld = 1'b0;
        if (stall && (b % 3 == 1)) begin
          bit_en = 1'b0;
          @(posedge clk);
          #1;
        end
      end
      // frame f closed: expected content of frame f+1
      if (v) begin
        hold[0] = ch0_i; hold[1] = ch0_q; hold[2] = ch1_i; hold[3] = ch1_q;
      end
      if (!started) begin
        if (v) begin
          started = 1'b1;
          slot = 0;
          for (int k = 0; k < 4; k++) cur[k] = hold[k];
        end
      end else begin
        slot++;
        if (slot >= m_cfg) begin
          slot = 0;
          for (int k = 0; k < 4; k++) cur[k] = hold[k];
        end
      end
      push((started && !err_cfg) ? model_word(slot) : 16'h0);
    end
    bit_en = 1'b0;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      bad++;
      total++;
      $display("FAIL watchdog expired got=%0d exp=%0d", WD_CYCLES, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 R2 R3 R7: one channel IQ, M=3, padding of one zero word, low bits trimmed
    start(3, 0, 0, 0, 0, 0, "R1 R2 R3 R7");
    run(14, 2, 3, 0);
    // R3 boundary: M=2, no padding
    start(2, 0, 0, 0, 0, 1, "R3");
    run(12, 1, 2, 0);
    // R4 R7: two channels, M=6, full resolution
    start(6, 1, 0, 0, 0, 1, "R4 R7");
    run(16, 3, 6, 0);
    // R4 boundary: M=4, no padding
    start(4, 1, 0, 0, 0, 0, "R4");
    run(13, 2, 4, 0);
    // R5: one channel, Q only, M=2
    start(2, 0, 1, 1, 0, 1, "R5");
    run(10, 2, 2, 0);
    // R5: two channels, I only, M=3
    start(3, 1, 1, 0, 0, 1, "R5");
    run(12, 1, 3, 0);
    // R6 R7: 14-bit frames, M=5
    start(5, 0, 0, 0, 1, 0, "R6 R7");
    run(14, 2, 5, 0);
    // R10: strobes in every frame, M=4
    start(4, 0, 0, 0, 0, 1, "R10");
    run(14, 1, 1, 0);
    // R9: gaps in bit_en, M=4
    start(4, 0, 0, 1, 0, 1, "R9");
    run(10, 2, 4, 1);
    // R8: two channels IQ with M=3
    start(3, 1, 0, 0, 0, 1, "R8");
    run(8, 1, 3, 0);
    // R8: one channel IQ with M=1
    start(1, 0, 0, 0, 1, 1, "R8");
    run(6, 1, 1, 0);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule